// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets the cores of a cluster interrupt one another. Each core owns a register access port into the unit, and each core receives three interrupt level lines. A core raises cause n on any set of cores by writing a bitmask of target cores to the set address for cause n. Every core has a 16-bit pending-cause register. Any port can clear bits in that register by writing ones to it, and any port can read it back.

The 16 cause bits form four groups: bit 0 alone, bits 1 to 3, bits 4 to 7, and bits 8 to 15. A group is active while any of its bits is pending. A shared 8-bit partition register holds one 2-bit selector per group, and the selector chooses which of the three level lines that group drives. Each level line is the OR of every active group steered onto it. A selector value of 3 steers its group nowhere.

Each port write is decoded into one of four access kinds: `ACC_NONE`, `ACC_CLEAR`, `ACC_SET` and `ACC_PART`. The kind is chosen only by the address, and a write takes effect at the next clock edge. Two transitions can collide in one edge, and each has a fixed priority. When a set and a clear target the same cause bit, the bit ends up set. When several ports write the partition register, the lowest-numbered port wins.

Top module: `ipi_unit`

## Requirements
- R1: A write of mask M to address 0x140+n (n from 0 to 15) sets cause bit n in every core c whose bit M[c] is one. Other bits and other cores are left unchanged.
- R2: A write of value V to address 0x100+c clears, in core c's cause register, every bit where V[15:0] is one. Bits where V is zero keep their value.
- R3: A read of address 0x100+c returns core c's pending causes in bits [15:0], with zeros above. A read of 0x190 returns the partition register in bits [7:0], with zeros above.
- R4: The four cause groups are group 0 = bit 0, group 1 = bits 1 to 3, group 2 = bits 4 to 7 and group 3 = bits 8 to 15. A group is active when any of its bits is set.
- R5: A write to 0x190 stores bits [7:0] as the partition register. The selector for group g is bits [2g+1:2g]. Level line k of a core is one exactly when some active group of that core has selector k. A selector of 3 drives no line.
- R6: After reset, every cause register, the partition register and every level line are zero.
- R7: If a set and a clear reach the same cause bit of a core in the same cycle, from different ports, the bit is set afterwards.
- R8: The level lines are registered. A write presented before a clock edge shows on the lines right after that edge, and not before it.
- R9: If several ports write the partition register in the same cycle, the value from the lowest-numbered of those ports is stored.
- R10: Some write data and addresses have no effect on any cause or partition state: writes to unmapped addresses, clear writes to core indices of NUM_CORES or more, set writes to offsets of 16 or more, and mask bits at positions of NUM_CORES or more. Reads of any address other than the cause and partition registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | NUM_CORES | Per-port write strobe |
| bus_addr | input | NUM_CORES*10 | Per-port address, port p in bits [10p+9:10p] |
| bus_wdata | input | NUM_CORES*32 | Per-port write data, port p in bits [32p+31:32p] |
| bus_rdata | output | NUM_CORES*32 | Per-port read data, combinational from the address |
| ipi_lvl | output | NUM_CORES*3 | Per-core level lines, core c in bits [3c+2:3c] |

## Verification
Two collisions can occur in one cycle. In the first, one port sets a cause bit in a core while that core's own port writes an all-ones clear to the same register. The bench provokes this for every cause bit, and it passes only if the register reads back with exactly that one bit set and the level lines match. In the second, all four ports write different partition values at once, and then only ports 1 to 3 write. The stored value must come from the lowest port that wrote. Around these cases, the bench sweeps all 256 partition values under two cause patterns and every cause bit against every target mask.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CAUSE_W    = 16;
    localparam int CIDX_W     = $clog2(CAUSE_W);
    localparam int LVL_W      = 3;
    localparam int GRP_N      = 4;
    localparam int SEL_W      = 2;
    localparam int PART_W     = GRP_N * SEL_W;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 32;
    localparam int CORE_IDX_W = 6;

    localparam logic [ADDR_W-1:0] CAUSE_BASE = 10'h100;
    localparam logic [ADDR_W-1:0] SET_BASE   = 10'h140;
    localparam logic [ADDR_W-1:0] PART_ADDR  = 10'h190;

    typedef logic [CAUSE_W-1:0] cause_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CLEAR,
        ACC_SET,
        ACC_PART
    } acc_kind_e;

    // Cause bits that belong to group g.
    function automatic cause_t grp_mask(input int g);
        case (g)
            0:       return 16'h0001;
            1:       return 16'h000E;
            2:       return 16'h00F0;
            default: return 16'hFF00;
        endcase
    endfunction

endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output acc_kind_e             kind,
    output logic [CORE_IDX_W-1:0] core_idx,
    output logic [CIDX_W-1:0]     cause_idx,
    output logic [NUM_CORES-1:0]  tgt_mask,
    output cause_t                clr_data,
    output logic [PART_W-1:0]     part_data
);

    localparam logic [ADDR_W-1:0] CAUSE_END = CAUSE_BASE + ADDR_W'(NUM_CORES);
    localparam logic [ADDR_W-1:0] SET_END   = SET_BASE + ADDR_W'(CAUSE_W);

    // Address window decides the access kind; the strobe is applied by the caller.
    always_comb begin
        if (addr >= CAUSE_BASE && addr < CAUSE_END) begin
            kind = ACC_CLEAR;
        end else if (addr >= SET_BASE && addr < SET_END) begin
            kind = ACC_SET;
        end else if (addr == PART_ADDR) begin
            kind = ACC_PART;
        end else begin
            kind = ACC_NONE;
        end
    end

    assign core_idx  = CORE_IDX_W'(addr - CAUSE_BASE);
    assign cause_idx = CIDX_W'(addr - SET_BASE);
    assign tgt_mask  = wdata[NUM_CORES-1:0];
    assign clr_data  = wdata[CAUSE_W-1:0];
    assign part_data = wdata[PART_W-1:0];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CAUSE_W];

endmodule

// File: rtl/ipi_cause_reg.sv
module ipi_cause_reg
    import ipi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t set_bits,
    input  cause_t clr_bits,
    output cause_t cause_q,
    output cause_t cause_nx
);

    // Set is applied after clear, so a colliding set survives.
    assign cause_nx = (cause_q & ~clr_bits) | set_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_nx;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((cause_q & $past(set_bits)) == $past(set_bits))); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits & ~set_bits) != '0) |=> ((cause_q & $past(clr_bits & ~set_bits)) == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(cause_q)); // R10

endmodule

// File: rtl/ipi_level_map.sv
module ipi_level_map
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cause_t            cause_nx,
    input  logic [PART_W-1:0] part_nx,
    output logic [LVL_W-1:0]  lvl_q
);

    logic [GRP_N-1:0] grp_act;
    logic [LVL_W-1:0] lvl_nx;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        assign grp_act[g] = |(cause_nx & grp_mask(g));
    end

    always_comb begin
        lvl_nx = '0;
        for (int k = 0; k < LVL_W; k++) begin
            for (int g = 0; g < GRP_N; g++) begin
                if (grp_act[g] && part_nx[g*SEL_W +: SEL_W] == SEL_W'(k)) begin
                    lvl_nx[k] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_nx;
        end
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_nx == '0) |=> (lvl_q == '0)); // R5

    AST_SEL3_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (part_nx == '1) |=> (lvl_q == '0)); // R5

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        bus_wr,
    input  logic [NUM_CORES*ADDR_W-1:0] bus_addr,
    input  logic [NUM_CORES*DATA_W-1:0] bus_wdata,
    output logic [NUM_CORES*DATA_W-1:0] bus_rdata,
    output logic [NUM_CORES*LVL_W-1:0]  ipi_lvl
);

    acc_kind_e             kind      [NUM_CORES];
    logic [CORE_IDX_W-1:0] core_idx  [NUM_CORES];
    logic [CIDX_W-1:0]     cause_idx [NUM_CORES];
    logic [NUM_CORES-1:0]  tgt_mask  [NUM_CORES];
    cause_t                clr_data  [NUM_CORES];
    logic [PART_W-1:0]     part_data [NUM_CORES];
    logic [DATA_W-1:0]     rd_word   [NUM_CORES];

    cause_t set_bits [NUM_CORES];
    cause_t clr_bits [NUM_CORES];
    cause_t cause_q  [NUM_CORES];
    cause_t cause_nx [NUM_CORES];

    logic [PART_W-1:0]    part_q;
    logic [PART_W-1:0]    part_nx;
    logic [NUM_CORES-1:0] part_hit;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
        ipi_port_decode #(.NUM_CORES(NUM_CORES)) u_dec (
            .addr      (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata     (bus_wdata[p*DATA_W +: DATA_W]),
            .kind      (kind[p]),
            .core_idx  (core_idx[p]),
            .cause_idx (cause_idx[p]),
            .tgt_mask  (tgt_mask[p]),
            .clr_data  (clr_data[p]),
            .part_data (part_data[p])
        );
        assign bus_rdata[p*DATA_W +: DATA_W] = rd_word[p];
        assign part_hit[p] = (kind[p] == ACC_PART);
    end

    // Merge set and clear requests from all ports onto each core.
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            set_bits[c] = '0;
            clr_bits[c] = '0;
            for (int p = 0; p < NUM_CORES; p++) begin
                if (bus_wr[p]) begin
                    unique case (kind[p])
                        ACC_SET: begin
                            if (tgt_mask[p][c]) begin
                                set_bits[c][cause_idx[p]] = 1'b1;
                            end
                        end
                        ACC_CLEAR: begin
                            if (core_idx[p] == CORE_IDX_W'(c)) begin
                                clr_bits[c] = clr_bits[c] | clr_data[p];
                            end
                        end
                        ACC_PART, ACC_NONE: begin
                        end
                    endcase
                end
            end
        end
    end

    // Lowest-numbered writing port is applied last and therefore wins.
    always_comb begin
        part_nx = part_q;
        for (int p = NUM_CORES - 1; p >= 0; p--) begin
            if (bus_wr[p] && part_hit[p]) begin
                part_nx = part_data[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
        end else begin
            part_q <= part_nx;
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_CORES; p++) begin
            rd_word[p] = '0;
            unique case (kind[p])
                ACC_CLEAR: begin
                    for (int c = 0; c < NUM_CORES; c++) begin
                        if (core_idx[p] == CORE_IDX_W'(c)) begin
                            rd_word[p] = DATA_W'(cause_q[c]);
                        end
                    end
                end
                ACC_PART: rd_word[p] = DATA_W'(part_q);
                ACC_SET, ACC_NONE: rd_word[p] = '0;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        ipi_cause_reg u_cause (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_bits[c]),
            .clr_bits (clr_bits[c]),
            .cause_q  (cause_q[c]),
            .cause_nx (cause_nx[c])
        );
        ipi_level_map u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .cause_nx (cause_nx[c]),
            .part_nx  (part_nx),
            .lvl_q    (ipi_lvl[c*LVL_W +: LVL_W])
        );
    end

    AST_PART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr & part_hit) == '0) |=> $stable(part_q)); // R5

    AST_PART_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr[0] && part_hit[0]) |=> (part_q == $past(part_data[0]))); // R9

endmodule

// File: tb/ipi_unit_test.sv
`timescale 1ns/1ps
module ipi_unit_test;

    localparam int NC = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   wr = '0;
    logic [NC*10-1:0] addr = '0;
    logic [NC*32-1:0] wdata = '0;
    logic [NC*32-1:0] rdata;
    logic [NC*3-1:0]  lvl;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_cause [NC];
    logic [7:0]  m_part;

    always #5 clk = ~clk;

    ipi_unit #(.NUM_CORES(NC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ipi_lvl(lvl)
    );

    function automatic logic [2:0] exp_lvl(input logic [15:0] cs, input logic [7:0] pt);
        logic [3:0] g;
        logic [2:0] r;
        g[0] = cs[0];
        g[1] = |cs[3:1];
        g[2] = |cs[7:4];
        g[3] = |cs[15:8];
        r = '0;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = int'(pt[2*i +: 2]);
            if (s < 3) r[s] = r[s] | g[i];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int p, input logic [9:0] a, input logic [31:0] d);
        wr[p] = 1'b1;
        addr[p*10 +: 10] = a;
        wdata[p*32 +: 32] = d;
    endtask

    // Single modeled write: drives the port and updates the bench model.
    task automatic mw(input int p, input logic [9:0] a, input logic [31:0] d);
        put(p, a, d);
        if (a >= 10'h100 && a < 10'h100 + NC) begin
            m_cause[a - 10'h100] = m_cause[a - 10'h100] & ~d[15:0];
        end else if (a >= 10'h140 && a < 10'h150) begin
            for (int c = 0; c < NC; c++) begin
                if (d[c]) m_cause[c][a - 10'h140] = 1'b1;
            end
        end else if (a == 10'h190) begin
            m_part = d[7:0];
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr = '0;
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NC; c++) addr[c*10 +: 10] = 10'h100 + 10'(c);
        #1;
        for (int c = 0; c < NC; c++) begin
            chk($sformatf("R3 %s cause core%0d", tag, c), rdata[c*32 +: 32], {16'h0, m_cause[c]});
            chk($sformatf("R5 %s lvl core%0d", tag, c), {29'h0, lvl[c*3 +: 3]},
                {29'h0, exp_lvl(m_cause[c], m_part)});
        end
        addr[9:0] = 10'h190;
        #1;
        chk($sformatf("R3 %s partition", tag), rdata[31:0], {24'h0, m_part});
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        for (int c = 0; c < NC; c++) m_cause[c] = '0;
        m_part = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        check_all("R6 reset");

        // R4/R5: one group per core, sweep every partition value
        mw(0, 10'h140, 32'h1); tick();
        mw(1, 10'h143, 32'h2); tick();
        mw(2, 10'h147, 32'h4); tick();
        mw(3, 10'h14F, 32'h8); tick();
        for (int v = 0; v < 256; v++) begin
            mw(v % NC, 10'h190, 32'(v)); tick();
            check_all("R4 sweepA");
        end
        // R4: core0 with several groups active at once
        mw(1, 10'h142, 32'h1); tick();
        mw(2, 10'h145, 32'h1); tick();
        mw(3, 10'h149, 32'h3); tick();
        for (int v = 0; v < 256; v++) begin
            mw((v + 1) % NC, 10'h190, 32'(v)); tick();
            check_all("R4 sweepB");
        end

        // R1/R10: every cause bit against every target mask, junk upper mask bits
        for (int c = 0; c < NC; c++) begin mw(c, 10'h100 + 10'(c), 32'hFFFF); tick(); end
        check_all("R2 clear all");
        mw(0, 10'h190, 32'hE4); tick();
        for (int n = 0; n < 16; n++) begin
            for (int m = 0; m < 16; m++) begin
                mw(n % NC, 10'h140 + 10'(n), {28'hABCDE12, 4'(m)}); tick();
                check_all("R1 R10 set");
            end
            for (int c = 0; c < NC; c++) begin
                mw((c + 1) % NC, 10'h100 + 10'(c), 32'hFFFF_FFFF); tick();
            end
            check_all("R2 clear");
        end

        // R2: partial clears
        for (int n = 0; n < 16; n++) begin mw(0, 10'h140 + 10'(n), 32'hF); tick(); end
        mw(1, 10'h100, 32'h00F0); tick(); check_all("R2 part0");
        mw(2, 10'h101, 32'h0101); tick(); check_all("R2 part1");
        mw(3, 10'h102, 32'h8000); tick(); check_all("R2 part2");
        mw(0, 10'h103, 32'h0000); tick(); check_all("R2 zero");

        // R8: output changes only after the edge
        mw(0, 10'h100, 32'hFFFF); tick();
        check_all("R8 pre");
        mw(1, 10'h140, 32'h1);
        #1;
        chk("R8 before edge", {29'h0, lvl[2:0]}, 32'h0);
        tick();
        chk("R8 after edge", {29'h0, lvl[2:0]}, 32'h1);

        // R7: set and clear of the same bit in one cycle
        for (int n = 0; n < 16; n++) begin
            put(0, 10'h140 + 10'(n), 32'h4);
            put(2, 10'h102, 32'hFFFF);
            m_cause[2] = 16'(1 << n);
            tick();
            check_all("R7 collide");
        end

        // R9: several ports write the partition at once
        put(0, 10'h190, 32'h11); put(1, 10'h190, 32'h22);
        put(2, 10'h190, 32'h33); put(3, 10'h190, 32'h44);
        m_part = 8'h11; tick(); check_all("R9 all ports");
        put(1, 10'h190, 32'h5A); put(2, 10'h190, 32'h66); put(3, 10'h190, 32'h77);
        m_part = 8'h5A; tick(); check_all("R9 ports1to3");
        put(3, 10'h190, 32'hE4);
        m_part = 8'hE4; tick(); check_all("R9 port3");

        // R10: unmapped writes leave state, unmapped reads give zero
        mw(0, 10'h104, 32'hFFFF_FFFF); tick(); check_all("R10 core4");
        mw(1, 10'h150, 32'hFFFF_FFFF); tick(); check_all("R10 set16");
        mw(2, 10'h191, 32'hFFFF_FFFF); tick(); check_all("R10 0x191");
        mw(3, 10'h3FF, 32'hFFFF_FFFF); tick(); check_all("R10 0x3FF");
        addr[9:0] = 10'h140; #1; chk("R10 read set addr", rdata[31:0], 32'h0);
        addr[9:0] = 10'h104; #1; chk("R10 read core4", rdata[31:0], 32'h0);
        addr[9:0] = 10'h000; #1; chk("R10 read 0x000", rdata[31:0], 32'h0);

        finish_up();
    end

endmodule